// File: doc/BRIEF.md
# Fast Page Mode DRAM Access Controller

This block sits between a synchronous word-request port and a 1M x 16 asynchronous DRAM that supports fast page access. Each accepted request carries a 20-bit word address, a 16-bit write word, two byte enables and a direction flag. The controller splits the address into a row half and a column half and presents both on one shared 10-bit address bus. It sequences the row strobe, the two per-byte column strobes, write enable and output enable. Read data comes back on a one-cycle response strobe.

After a row has been opened it stays open. A later request to the same row needs only a column strobe pulse. The page is closed when a request targets another row, when the external refresh engine raises a refresh request, or when no access arrives for an idle interval. Refresh is done by strobing the column lines before the row strobe. This uses the memory's internal row counter, so the address pins carry nothing of meaning during refresh. Every timing interval is a parameter counted in clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row is `req_addr[19:10]` and is on `dram_addr` when `dram_ras_n` falls. The column is `req_addr[9:0]` and is on `dram_addr` when a column strobe falls.
- R2: During and after reset, `dram_ras_n`, both column strobes, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high while idle with no refresh pending.
- R3: Back-to-back requests to the open row cause no new fall of `dram_ras_n`. Between column pulses, both column strobes stay high for at least `T_CP` cycles.
- R4: A write is an early write. `dram_we_n` falls and `dram_dq_oe` is set while both column strobes are high, and both stay asserted through the column pulse. `dram_oe_n` stays high whenever `dram_we_n` is low.
- R5: Byte enable bit 0 drives `dram_lcas_n` (data bits 7:0) and bit 1 drives `dram_ucas_n` (bits 15:8). A disabled lane's strobe stays high, a disabled lane keeps its stored byte on writes, and a disabled lane returns zero in `rsp_rdata` on reads.
- R6: `dram_ras_n` stays low for at least `T_RAS` cycles. Before each fall it stays high for at least `T_RP` cycles.
- R7: The open page is closed (`dram_ras_n` rises) when a request to a different row arrives, or when `T_IDLE` cycles pass after the last column access with no new access.
- R8: When `ref_req` is high, the controller closes any open page and precharges. It then holds both column strobes low for `T_CSR` cycles before `dram_ras_n` falls, and keeps `dram_ras_n` low for `T_RAS` cycles. `ref_ack` is a single-cycle pulse while both strobes and `dram_ras_n` are low. A refresh is served before any waiting request, and no data is driven during it.
- R9: `dram_oe_n` is low only during read column pulses, and `dram_dq_oe` is never high while `dram_oe_n` is low. Read data returns on `rsp_valid` in request order.
- R10: `req_ready` is low whenever a column strobe is low, and in the cycle after a request is accepted.
- R11: The first column strobe fall after `dram_ras_n` falls comes no sooner than `T_RCD + 1` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in bits 19:10 |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh wanted, held until acknowledged |
| ref_ack | output | 1 | Refresh cycle done |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Write data toward the memory |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
The properties assume that a request, once raised, holds its fields until `req_ready` takes it. They also assume that `ref_req` stays high until `ref_ack` arrives, and that every timing parameter is at least one cycle. The bench meets these assumptions by changing inputs only half a cycle away from the active edge, by keeping each request steady until it is accepted, and by releasing refresh only on the acknowledge. A memory model in the bench decodes the pin waveform on its own. It fills the data bus with ones on any lane whose strobe is not low, so that lane masking and capture timing show up in the returned words.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int ROW_W  = 10;
    localparam int COL_W  = 10;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DQ_W   = LANES * LANE_W;
    localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef enum logic [3:0] {
        S_IDLE,    // row closed, precharge met
        S_ROW,     // row address set up, strobe still high
        S_ACT,     // row strobe low, row-to-column wait
        S_COLSET,  // column address, write enable and data set up
        S_COL,     // column strobe pulse
        S_PAGE,    // row open, column strobes high
        S_PRE,     // row strobe high, precharge wait
        S_RCAS,    // refresh: column strobes low first
        S_RRAS     // refresh: row strobe low
    } fpm_state_e;

    typedef struct packed {
        logic              write;
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   wdata;
    } fpm_req_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int T_RCD  = 7,
    parameter int T_CAS  = 7,
    parameter int T_CP   = 3,
    parameter int T_RAS  = 15,
    parameter int T_RP   = 10,
    parameter int T_CSR  = 3,
    parameter int T_IDLE = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       row_hit,
    input  logic       ref_req,
    output fpm_state_e state,
    output logic       ready,
    output logic       accept,
    output logic       capture,
    output logic       ref_ack
);
    localparam int TMAX = max_of(max_of(max_of(T_RCD, T_CAS), max_of(T_CP, T_RAS)),
                                 max_of(max_of(T_RP, T_CSR), T_IDLE));
    localparam int TW   = $clog2(TMAX + 1);

    function automatic logic [TW-1:0] cyc(input int n);
        return TW'(n - 1);
    endfunction

    fpm_state_e nxt;
    logic          st_ld, ras_ld, idle_ld;
    logic [TW-1:0] st_val;
    logic          st_done, ras_done, idle_done;

    fpm_timer #(.W(TW)) i_st_tmr   (.clk(clk), .rst(rst), .load(st_ld),
                                    .value(st_val),       .done(st_done));
    fpm_timer #(.W(TW)) i_ras_tmr  (.clk(clk), .rst(rst), .load(ras_ld),
                                    .value(cyc(T_RAS)),   .done(ras_done));
    fpm_timer #(.W(TW)) i_idle_tmr (.clk(clk), .rst(rst), .load(idle_ld),
                                    .value(cyc(T_IDLE)),  .done(idle_done));

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt     = state;
        st_ld   = 1'b0;
        st_val  = '0;
        ras_ld  = 1'b0;
        idle_ld = 1'b0;
        ready   = 1'b0;
        accept  = 1'b0;
        capture = 1'b0;
        ref_ack = 1'b0;
        unique case (state)
            S_IDLE: begin
                ready = !ref_req;
                if (ref_req) begin
                    nxt    = S_RCAS;
                    st_ld  = 1'b1;
                    st_val = cyc(T_CSR);
                end else if (req_valid) begin
                    accept = 1'b1;
                    nxt    = S_ROW;
                end
            end
            S_ROW: begin
                nxt    = S_ACT;
                st_ld  = 1'b1;
                st_val = cyc(T_RCD);
                ras_ld = 1'b1;
            end
            S_ACT: if (st_done) nxt = S_COLSET;
            S_COLSET: begin
                nxt    = S_COL;
                st_ld  = 1'b1;
                st_val = cyc(T_CAS);
            end
            S_COL: if (st_done) begin
                capture = 1'b1;
                nxt     = S_PAGE;
                st_ld   = 1'b1;
                st_val  = cyc(T_CP);
                idle_ld = 1'b1;
            end
            S_PAGE: if (st_done) begin
                if (ref_req || idle_done || (req_valid && !row_hit)) begin
                    if (ras_done) begin
                        nxt    = S_PRE;
                        st_ld  = 1'b1;
                        st_val = cyc(T_RP);
                    end
                end else begin
                    ready = 1'b1;
                    if (req_valid) begin
                        accept = 1'b1;
                        nxt    = S_COLSET;
                    end
                end
            end
            S_PRE: if (st_done) nxt = S_IDLE;
            S_RCAS: if (st_done) begin
                nxt    = S_RRAS;
                st_ld  = 1'b1;
                st_val = cyc(T_RAS);
            end
            S_RRAS: if (st_done) begin
                ref_ack = 1'b1;
                nxt     = S_PRE;
                st_ld   = 1'b1;
                st_val  = cyc(T_RP);
            end
            default: nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/fpm_addr_path.sv
module fpm_addr_path
    import fpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             capture,
    input  fpm_req_t         req_in,
    input  fpm_state_e       state,
    input  logic [DQ_W-1:0]  dq_in,
    output fpm_req_t         cur,
    output logic             row_hit,
    output logic [PIN_W-1:0] pin_addr,
    output logic             rsp_valid,
    output logic [DQ_W-1:0]  rsp_rdata
);
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic             take;

    always_ff @(posedge clk) begin
        if (rst)         cur <= '0;
        else if (accept) cur <= req_in;
    end

    assign cur_row = cur.addr[ADDR_W-1 -: ROW_W];
    assign cur_col = cur.addr[COL_W-1:0];
    assign row_hit = (req_in.addr[ADDR_W-1 -: ROW_W] == cur_row);

    always_comb begin
        if (state == S_ROW || state == S_ACT)
            pin_addr = PIN_W'(cur_row);
        else
            pin_addr = PIN_W'(cur_col);
    end

    assign take = capture && !cur.write;

    always_ff @(posedge clk) begin
        if (rst) rsp_valid <= 1'b0;
        else     rsp_valid <= take;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            else if (take)
                rsp_rdata[g*LANE_W +: LANE_W] <= cur.be[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int T_RCD  = 7,
    parameter int T_CAS  = 7,
    parameter int T_CP   = 3,
    parameter int T_RAS  = 15,
    parameter int T_RP   = 10,
    parameter int T_CSR  = 3,
    parameter int T_IDLE = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DQ_W-1:0]   rsp_rdata,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic              dram_ras_n,
    output logic              dram_lcas_n,
    output logic              dram_ucas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [PIN_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    fpm_state_e       state;
    fpm_req_t         req_in, cur;
    logic             accept, capture, row_hit;
    logic [LANES-1:0] cas_n;

    assign req_in = '{write: req_write, be: req_be, addr: req_addr, wdata: req_wdata};

    fpm_seq #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS(T_RAS),
        .T_RP(T_RP), .T_CSR(T_CSR), .T_IDLE(T_IDLE)
    ) i_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .row_hit(row_hit),
        .ref_req(ref_req), .state(state), .ready(req_ready), .accept(accept),
        .capture(capture), .ref_ack(ref_ack)
    );

    fpm_addr_path i_path (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .req_in(req_in), .state(state), .dq_in(dram_dq_in), .cur(cur),
        .row_hit(row_hit), .pin_addr(dram_addr), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    always_comb begin
        dram_ras_n = 1'b1;
        cas_n      = '1;
        dram_we_n  = 1'b1;
        dram_oe_n  = 1'b1;
        dram_dq_oe = 1'b0;
        unique case (state)
            S_ACT, S_PAGE: dram_ras_n = 1'b0;
            S_COLSET: begin
                dram_ras_n = 1'b0;
                dram_we_n  = !cur.write;
                dram_dq_oe = cur.write;
            end
            S_COL: begin
                dram_ras_n = 1'b0;
                cas_n      = ~cur.be;
                dram_we_n  = !cur.write;
                dram_oe_n  = cur.write;
                dram_dq_oe = cur.write;
            end
            S_RCAS: cas_n = '0;
            S_RRAS: begin
                dram_ras_n = 1'b0;
                cas_n      = '0;
            end
            default: ;
        endcase
    end

    assign dram_lcas_n = cas_n[0];
    assign dram_ucas_n = cas_n[LANES-1];
    assign dram_dq_out = cur.wdata;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
    parameter int T_RAS = 15,
    parameter int T_RP  = 10
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic ref_ack,
    input logic dram_ras_n,
    input logic dram_lcas_n,
    input logic dram_ucas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);
    localparam int LIM = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int CW  = $clog2(LIM + 2);

    logic [CW-1:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= CW'(T_RP);
        end else if (dram_ras_n) begin
            lo_cnt <= '0;
            if (hi_cnt < CW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            if (lo_cnt < CW'(T_RAS)) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    assert_ras_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_ras_n) |-> lo_cnt >= CW'(T_RAS));

    assert_precharge_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> hi_cnt >= CW'(T_RP));

    assert_early_we_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_we_n) |-> (dram_lcas_n && dram_ucas_n && dram_dq_oe));

    assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> dram_oe_n);

    assert_no_bus_fight_R9: assert property (@(posedge clk) disable iff (rst)
        !dram_oe_n |-> !dram_dq_oe);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        (!dram_lcas_n || !dram_ucas_n) |-> !req_ready);

    assert_ack_in_refresh_R8: assert property (@(posedge clk) disable iff (rst)
        ref_ack |-> (!dram_ras_n && !dram_lcas_n && !dram_ucas_n && dram_oe_n && !dram_dq_oe));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) i_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .ref_ack(ref_ack),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;
    localparam int T_RCD = 7, T_CAS = 7, T_CP = 3, T_RAS = 15;
    localparam int T_RP = 10, T_CSR = 3, T_IDLE = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ref_req = 1'b0;
    logic [15:0] dram_dq_in = '1;
    logic        req_ready, rsp_valid, ref_ack;
    logic [15:0] rsp_rdata, dram_dq_out;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0]  dram_addr;

    always #2 clk = ~clk;

    fpm_dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS(T_RAS),
                    .T_RP(T_RP), .T_CSR(T_CSR), .T_IDLE(T_IDLE)) i_fpm_dram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_req(ref_req), .ref_ack(ref_ack), .dram_ras_n(dram_ras_n),
        .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [15:0] init_word(input logic [19:0] key);
        return key[15:0] ^ 16'hA55A;
    endfunction

    // independent memory model driven by pin activity
    logic [15:0] mem [logic [19:0]];
    logic [15:0] ref_mem [logic [19:0]];
    logic [15:0] exp_q [$];
    logic [19:0] cur_addr = '0;
    logic [1:0]  cur_be = '0;

    function automatic logic [15:0] mem_rd(input logic [19:0] k);
        return mem.exists(k) ? mem[k] : init_word(k);
    endfunction
    function automatic logic [15:0] ref_rd(input logic [19:0] k);
        return ref_mem.exists(k) ? ref_mem[k] : init_word(k);
    endfunction

    int ras_falls = 0, cbr_cnt = 0, acks = 0;
    int lo_cnt = 0, hi_cnt = 1000, cas_hi = 1000, since_ras = 0, ack_run = 0;
    bit first_cas = 0;
    logic prev_ras = 1'b1;
    logic [1:0] prev_cas = 2'b11;
    logic [9:0] open_row = '0, col = '0;

    always @(negedge clk) begin : model
        logic [1:0]  casv, fell, lane_mask_w;
        logic [15:0] m, wm;
        if (rst) begin
            prev_ras = 1'b1; prev_cas = 2'b11; hi_cnt = 1000; lo_cnt = 0; cas_hi = 1000;
        end else begin
            casv = {dram_ucas_n, dram_lcas_n};
            fell = prev_cas & ~casv;
            if (prev_ras && !dram_ras_n) begin
                if (casv == 2'b11) begin
                    ras_falls++;
                    check("R6 precharge before row strobe", 32'(hi_cnt >= T_RP), 1);
                    check("R1 row on pins", 32'(dram_addr), 32'(cur_addr[19:10]));
                    open_row = dram_addr; since_ras = 0; first_cas = 1; cas_hi = 1000;
                end else begin
                    cbr_cnt++;
                    check("R8 strobes low before row strobe", 32'(casv), 0);
                    check("R8 no data driven in refresh", 32'(dram_dq_oe), 0);
                end
            end
            if (!prev_ras && dram_ras_n)
                check("R6 row strobe low width", 32'(lo_cnt >= T_RAS), 1);
            if (fell != 2'b00 && !dram_ras_n) begin
                col = dram_addr;
                check("R1 column on pins", 32'(dram_addr), 32'(cur_addr[9:0]));
                check("R5 only enabled lanes strobe", 32'(fell & ~cur_be), 0);
                check("R3 column precharge", 32'(cas_hi >= T_CP), 1);
                if (first_cas) check("R11 row to column delay", 32'(since_ras >= T_RCD + 1), 1);
                first_cas = 0;
                if (!dram_we_n) begin
                    check("R4 driver on at strobe", 32'(dram_dq_oe), 1);
                    check("R4 output enable high in write", 32'(dram_oe_n), 1);
                    lane_mask_w = fell;
                    wm = {{8{lane_mask_w[1]}}, {8{lane_mask_w[0]}}};
                    m = mem_rd({open_row, col});
                    mem[{open_row, col}] = (m & ~wm) | (dram_dq_out & wm);
                end
            end
            if (!dram_oe_n) check("R9 driver off while output enabled", 32'(dram_dq_oe), 0);
            if (ref_ack) begin ack_run++; acks++; end
            else if (ack_run != 0) begin
                check("R8 ack one cycle", 32'(ack_run), 1);
                ack_run = 0;
            end
            m = mem_rd({open_row, col});
            for (int l = 0; l < 2; l++)
                dram_dq_in[l*8 +: 8] = (!dram_ras_n && !casv[l] && !dram_oe_n) ? m[l*8 +: 8] : 8'hFF;
            if (dram_ras_n) begin hi_cnt++; lo_cnt = 0; end
            else begin lo_cnt++; hi_cnt = 0; since_ras++; end
            if (casv == 2'b11) cas_hi++; else cas_hi = 0;
            prev_ras = dram_ras_n; prev_cas = casv;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) check("R9 unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
            else check("R9 R5 read data", 32'(rsp_rdata), 32'(exp_q.pop_front()));
        end
    end

    task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] wm, old;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        cur_addr = a; cur_be = be;
        wm = {{8{be[1]}}, {8{be[0]}}};
        if (wr) begin
            old = ref_rd(a);
            ref_mem[a] = (old & ~wm) | (d & wm);
        end else
            exp_q.push_back(ref_rd(a) & wm);
    endtask

    task automatic do_refresh();
        @(negedge clk);
        ref_req = 1'b1;
        do @(negedge clk); while (!ref_ack);
        ref_req = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
        check("R9 all responses returned", 32'(exp_q.size()), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        int f0, c0, a0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R2 reset row strobe", 32'(dram_ras_n), 1);
        check("R2 reset column strobes", 32'({dram_ucas_n, dram_lcas_n}), 3);
        check("R2 reset we oe", 32'({dram_we_n, dram_oe_n}), 3);
        check("R2 reset driver and response", 32'({dram_dq_oe, rsp_valid}), 0);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R2 ready when idle", 32'(req_ready), 1);

        // page hits, byte lanes
        f0 = ras_falls;
        issue(1, {10'd3, 10'd5}, 16'h1234, 2'b11);
        check("R10 not ready after accept", 32'(req_ready), 0);
        issue(0, {10'd3, 10'd5}, 16'h0, 2'b11);
        issue(1, {10'd3, 10'd6}, 16'hABCD, 2'b01);
        issue(0, {10'd3, 10'd6}, 16'h0, 2'b11);
        issue(0, {10'd3, 10'd5}, 16'h0, 2'b10);
        issue(1, {10'd3, 10'd5}, 16'h7700, 2'b10);
        issue(0, {10'd3, 10'd5}, 16'h0, 2'b11);
        drain();
        check("R3 one row open for page hits", 32'(ras_falls - f0), 1);

        // row miss
        f0 = ras_falls;
        issue(0, {10'd7, 10'd2}, 16'h0, 2'b11);
        issue(1, {10'd7, 10'd3}, 16'h5151, 2'b11);
        issue(0, {10'd3, 10'd6}, 16'h0, 2'b11);
        drain();
        check("R7 row miss reopens", 32'(ras_falls - f0), 2);

        // idle timeout
        repeat (T_IDLE + T_RP + 20) @(negedge clk);
        check("R7 idle close", 32'(dram_ras_n), 1);

        // refresh from idle
        f0 = ras_falls; c0 = cbr_cnt; a0 = acks;
        do_refresh();
        repeat (T_RP + 4) @(negedge clk);
        check("R8 refresh cycle seen", 32'(cbr_cnt - c0), 1);
        check("R8 ack seen", 32'(acks - a0), 1);
        check("R8 no row open in refresh", 32'(ras_falls - f0), 0);

        // refresh while page open, with a waiting hit
        f0 = ras_falls; c0 = cbr_cnt;
        issue(0, {10'd9, 10'd1}, 16'h0, 2'b11);
        fork
            do_refresh();
            issue(0, {10'd9, 10'd2}, 16'h0, 2'b01);
        join
        drain();
        check("R8 refresh served first", 32'(cbr_cnt - c0), 1);
        check("R7 R8 page closed for refresh", 32'(ras_falls - f0), 2);

        // burst of page writes and reads across lanes
        f0 = ras_falls;
        for (int i = 0; i < 8; i++)
            issue(1, {10'd300, 10'(i)}, 16'(16'h1111 * (i + 1)), 2'(i % 3 + 1));
        for (int i = 0; i < 8; i++)
            issue(0, {10'd300, 10'(i)}, 16'h0, 2'b11);
        drain();
        check("R3 burst in one page", 32'(ras_falls - f0), 1);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule